// File: doc/BRIEF.md
# Ring-Oscillator Random Bit Collector

This block gathers random bits from one of four external noise inputs and packs them into eight 32-bit result words that a host reads over a simple register interface. The host first loads a sample period, then writes a control word that names the noise source and the request length (64, 128, 192 or 256 bits) with both the enable and start bits set. While the request runs, the start bit reads back as one. It falls to zero on its own in the cycle after the last bit is stored, and the host then reads the result words.

One bit is taken from the chosen source every sample period. Bits fill result word 0 from its least significant bit upward, then word 1, and so on. A new request clears all result words, so any word past the requested length reads as zero. A control write with the enable bit clear stops a request at once. A start request without the enable bit is dropped. Noise inputs can pass through an optional synchronizer chain, chosen by parameter.

Top module: `rng_sample_ctrl`

## Requirements
- R1: After reset, the control register, the sample-period register and all result words read zero.
- R2: A control write at offset 0x400 with bit 1 (enable) and bit 0 (start) both set, issued while idle, sets start. Control reads back as {len[5:4], source[3:2], enable[1], start[0]}, and start is never set while enable is clear.
- R3: Start clears by itself exactly N*P clock cycles after the starting write, where N is the request length in bits and P is the effective sample period.
- R4: Control bits 5:4 select the length: code 0 is 64 bits, 1 is 128, 2 is 192 and 3 is 256. Result words beyond the length read zero.
- R5: Sampled bits are stored least significant bit first, word 0 first. Word i is read at offset 0x410 + 4*i, for i from 0 to 7.
- R6: Control bits 3:2 choose which noise input (0 to 3) is sampled.
- R7: The register at offset 0x404 holds P, the number of clock cycles between samples. The first sample is taken P cycles after the start write, and a value of 0 behaves as 1.
- R8: A control write with bit 1 clear and bit 0 set does not start a request: start stays zero and the result words are unchanged.
- R9: A control write of zero in bits 15:0 clears enable and start at once, ending any running request.
- R10: Reads of unmapped offsets return zero, and unused control bits read zero.
- R11: A control write with enable set while a request runs leaves the control fields unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| noise_in | input | 4 | Noise bit from each entropy source |

## Verification
The checker tests every cycle that start only rises after a write with both enable and start set, that start never sits without enable, and that a clear or zero control write never leaves a request running. It also tests that the bit index moves only on a sample tick, stays inside the chosen length, and that the last stored bit ends the request. Unmapped reads are checked for zero on every cycle. The exact completion cycle, the bit packing order, the source choice and the effect of each length and period code can only be shown by the bench scenarios, which compare the result words with bits recorded from the driven noise inputs.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
   localparam int ADDR_W = 12;
   localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h400;
   localparam logic [ADDR_W-1:0] OFF_PER  = 12'h404;
   localparam logic [ADDR_W-1:0] OFF_DATA = 12'h410;

   typedef struct packed {
      logic [1:0] len;
      logic [1:0] src;
      logic       en;
      logic       start;
   } ctrl_view_t;
endpackage

// File: rtl/rng_noise_sync.sv
module rng_noise_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= din;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rng_period_timer.sv
module rng_period_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] period,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = (period == '0) ? '0 : period - CNT_W'(1);
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart || !run)  cnt_q <= '0;
      else if (tick)             cnt_q <= '0;
      else                       cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/rng_bit_collector.sv
module rng_bit_collector #(
   parameter int DATA_W  = 32,
   parameter int N_WORDS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clear,
   input  logic                           sample,
   input  logic                           bit_in,
   input  logic [1:0]                     len,
   output logic [N_WORDS-1:0][DATA_W-1:0] words,
   output logic [$clog2(N_WORDS*DATA_W)-1:0] idx,
   output logic                           last
);
   localparam int TOTAL_BITS = N_WORDS * DATA_W;
   localparam int IDX_W      = $clog2(TOTAL_BITS);
   localparam int LOG_DW     = $clog2(DATA_W);
   localparam int STEP_BITS  = TOTAL_BITS / 4;

   logic [IDX_W-1:0] last_idx;

   assign last_idx = IDX_W'((int'(len) + 1) * STEP_BITS - 1);
   assign last     = sample && (idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words <= '0;
         idx   <= '0;
      end else if (clear) begin
         words <= '0;
         idx   <= '0;
      end else if (sample) begin
         words[idx[IDX_W-1:LOG_DW]][idx[LOG_DW-1:0]] <= bit_in;
         idx <= idx + IDX_W'(1);
      end
   end
endmodule

// File: rtl/rng_sample_ctrl.sv
module rng_sample_ctrl
   import rng_ctrl_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int N_WORDS     = 8,
   parameter int CNT_W       = 16,
   parameter int N_SRC       = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_SRC-1:0]  noise_in
);
   localparam int TOTAL_BITS = N_WORDS * DATA_W;
   localparam int IDX_W      = $clog2(TOTAL_BITS);
   localparam int WSEL_W     = $clog2(N_WORDS);
   localparam logic [ADDR_W-1:0] DATA_END = OFF_DATA + ADDR_W'(4 * N_WORDS);

   generate
      if (N_SRC != 4)                    begin : g_bad_src  $error("N_SRC must be 4"); end
      if (N_WORDS % 4 != 0 || N_WORDS < 4) begin : g_bad_wn   $error("N_WORDS must be a multiple of 4"); end
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0)
                                         begin : g_bad_dw   $error("DATA_W must be a power of two >= 16"); end
      if (CNT_W > DATA_W || CNT_W < 1)   begin : g_bad_cw   $error("CNT_W out of range"); end
      if (SYNC_STAGES < 0)               begin : g_bad_sync $error("SYNC_STAGES negative"); end
   endgenerate

   logic                           ctrl_en, busy;
   logic [1:0]                     ctrl_src, ctrl_len;
   logic [CNT_W-1:0]               samp_period;
   logic                           tick, done;
   logic [N_SRC-1:0]               noise_s;
   logic [N_WORDS-1:0][DATA_W-1:0] words;
   logic [IDX_W-1:0]               bit_idx;
   logic                           wr_ctrl, start_req;
   ctrl_view_t                     ctrl_view;

   assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
   assign start_req = wr_ctrl && (bus_wdata[1:0] == 2'b11) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         busy     <= 1'b0;
         ctrl_src <= '0;
         ctrl_len <= '0;
      end else if (wr_ctrl && !bus_wdata[1]) begin
         ctrl_en  <= 1'b0;
         busy     <= 1'b0;
         ctrl_src <= bus_wdata[3:2];
         ctrl_len <= bus_wdata[5:4];
      end else if (wr_ctrl && !busy) begin
         ctrl_en  <= 1'b1;
         busy     <= bus_wdata[0];
         ctrl_src <= bus_wdata[3:2];
         ctrl_len <= bus_wdata[5:4];
      end else if (done) begin
         busy     <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  samp_period <= '0;
      else if (bus_wr && bus_addr == OFF_PER)      samp_period <= bus_wdata[CNT_W-1:0];
   end

   rng_noise_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(noise_in), .dout(noise_s)
   );

   rng_period_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .restart(start_req),
      .period(samp_period), .tick(tick)
   );

   rng_bit_collector #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_coll (
      .clk(clk), .rst_n(rst_n), .clear(start_req), .sample(tick),
      .bit_in(noise_s[ctrl_src]), .len(ctrl_len),
      .words(words), .idx(bit_idx), .last(done)
   );

   logic [ADDR_W-1:0] data_off;
   logic              data_hit;
   assign data_off  = bus_addr - OFF_DATA;
   assign data_hit  = (bus_addr >= OFF_DATA) && (bus_addr < DATA_END) && (bus_addr[1:0] == 2'b00);
   assign ctrl_view = '{len: ctrl_len, src: ctrl_src, en: ctrl_en, start: busy};

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFF_CTRL)      bus_rdata[$bits(ctrl_view_t)-1:0] = ctrl_view;
      else if (bus_addr == OFF_PER)  bus_rdata[CNT_W-1:0] = samp_period;
      else if (data_hit)             bus_rdata = words[data_off[2 +: WSEL_W]];
   end
endmodule

// File: rtl/rng_sample_ctrl_chk.sv
module rng_sample_ctrl_chk
   import rng_ctrl_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int N_WORDS = 8,
   parameter int IDX_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              busy,
   input logic              ctrl_en,
   input logic [1:0]        ctrl_len,
   input logic [IDX_W-1:0]  bit_idx,
   input logic              tick
);
   localparam int STEP_BITS = N_WORDS * DATA_W / 4;
   localparam logic [ADDR_W-1:0] DATA_END = OFF_DATA + ADDR_W'(4 * N_WORDS);

   logic wr_ctrl, unmapped;
   int   n_bits;
   assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
   assign n_bits   = (int'(ctrl_len) + 1) * STEP_BITS;
   assign unmapped = (bus_addr != OFF_CTRL) && (bus_addr != OFF_PER) &&
                     !((bus_addr >= OFF_DATA) && (bus_addr < DATA_END) && (bus_addr[1:0] == 2'b00));

   p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_ctrl && bus_wdata[1:0] == 2'b11));
   p_busy_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ctrl_en);
   p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && int'(bit_idx) == n_bits - 1 && !wr_ctrl) |=> !busy);
   p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> int'(bit_idx) < n_bits);
   p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(bit_idx));
   p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata[1]) |=> !busy);
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[15:0] == 16'h0) |=> (!ctrl_en && !busy));
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> bus_rdata == '0);
endmodule

bind rng_sample_ctrl rng_sample_ctrl_chk #(
   .DATA_W(DATA_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
   .ctrl_en(ctrl_en), .ctrl_len(ctrl_len), .bit_idx(bit_idx), .tick(tick)
);

// File: tb/tb_rng_sample_ctrl.sv
`timescale 1ns/1ps
module tb_rng_sample_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  noise_in = '0;

   int errors = 0;
   int checks = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] exp_w [8];

   always #2.5 clk = ~clk;

   rng_sample_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .noise_in(noise_in)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #0.5;
      bus_wr = 1'b0;
   endtask

   function automatic logic [3:0] next_noise();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[3:0];
   endfunction

   task automatic check_words(input string req);
      logic [31:0] d;
      for (int i = 0; i < 8; i++) begin
         rd(12'h410 + 12'(4 * i), d);
         check(d == exp_w[i], req, d, exp_w[i]);
      end
   endtask

   // R2 R3 R4 R5 R6 R7: one full request with given length code, source and period
   task automatic t_run(input int len, input int src, input int per);
      int p = (per == 0) ? 1 : per;
      int nbits = (len + 1) * 64;
      int total = nbits * p;
      int b = 0;
      logic [31:0] d;
      logic [3:0] nz;
      for (int i = 0; i < 8; i++) exp_w[i] = '0;
      wr(12'h404, 32'(per));
      rd(12'h404, d);
      check(d == 32'(per), "R7 period readback", d, 32'(per));
      wr(12'h400, 32'((len << 4) | (src << 2) | 3));
      for (int k = 1; k <= total; k++) begin
         @(negedge clk);
         nz = next_noise();
         noise_in = nz;
         if (k == 1) begin
            rd(12'h400, d);
            check(d == 32'((len << 4) | (src << 2) | 3), "R2 running control readback", d,
                  32'((len << 4) | (src << 2) | 3));
         end
         if (k == total) begin
            rd(12'h400, d);
            check(d[0] == 1'b1, "R3 start still set before last sample", d, 32'(1));
         end
         @(posedge clk);
         if (k % p == 0) begin
            exp_w[b / 32][b % 32] = nz[src];
            b++;
         end
      end
      #0.5;
      rd(12'h400, d);
      check(d == 32'((len << 4) | (src << 2) | 2), "R3 start self-cleared on time", d,
            32'((len << 4) | (src << 2) | 2));
      check_words($sformatf("R4 R5 R6 R7 words len=%0d src=%0d per=%0d", len, src, per));
   endtask

   // R1: reset values
   task automatic t_reset();
      logic [31:0] d;
      rd(12'h400, d); check(d == 0, "R1 control reset", d, 0);
      rd(12'h404, d); check(d == 0, "R1 period reset", d, 0);
      rd(12'h410, d); check(d == 0, "R1 word0 reset", d, 0);
      rd(12'h42C, d); check(d == 0, "R1 word7 reset", d, 0);
   endtask

   // R8: start without enable is ignored
   task automatic t_no_enable();
      logic [31:0] d;
      wr(12'h400, 32'h31);
      repeat (80) @(negedge clk);
      rd(12'h400, d);
      check(d == 32'h30, "R8 start without enable", d, 32'h30);
      check_words("R8 words unchanged");
   endtask

   // R11 then R9: busy write ignored, then zero write aborts
   task automatic t_busy_and_abort();
      logic [31:0] d;
      wr(12'h404, 32'd4);
      wr(12'h400, 32'h07);
      repeat (10) @(negedge clk);
      wr(12'h400, 32'h3E);
      rd(12'h400, d);
      check(d == 32'h07, "R11 busy write ignored", d, 32'h07);
      repeat (5) @(negedge clk);
      wr(12'h400, 32'h0);
      rd(12'h400, d);
      check(d == 0, "R9 zero write aborts", d, 0);
      repeat (300) @(negedge clk);
      rd(12'h400, d);
      check(d == 0, "R9 stays stopped", d, 0);
   endtask

   // R10: unmapped offsets and unused control bits read zero
   task automatic t_unmapped();
      logic [31:0] d;
      rd(12'h408, d); check(d == 0, "R10 offset 0x408", d, 0);
      rd(12'h430, d); check(d == 0, "R10 offset 0x430", d, 0);
      rd(12'h000, d); check(d == 0, "R10 offset 0x000", d, 0);
      rd(12'h412, d); check(d == 0, "R10 unaligned 0x412", d, 0);
      wr(12'h400, 32'hFFFF_FFC2);
      rd(12'h400, d); check(d == 32'h02, "R10 unused control bits", d, 32'h02);
      wr(12'h400, 32'h0);
   endtask

   initial begin
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #12 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run(0, 0, 1);
      t_run(3, 2, 1);
      t_no_enable();
      t_run(1, 1, 3);
      t_run(2, 3, 0);
      t_busy_and_abort();
      t_unmapped();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule